// File: doc/BRIEF.md
# Lockdown-Aware Memory Permission Checker

This block decides whether one memory access from a hart may proceed. It looks at the access's byte address, its length in bytes, the permissions it needs (read, write, execute) and the privilege level that issues it. It then compares these against a parameterized set of protection entries. Each entry is a configuration byte plus an address register. Three security control bits change how the entries are read. When the lockdown bit is set, machine mode loses its implicit rights. Each entry's lock, read, write and execute bits then form a 4-bit code, and that code selects separate grants for machine mode and for the lower modes. Some codes describe regions that both sides share.

The block is a pure checking function followed by one register stage. The decision, a flag that says whether an entry matched, and the index of the entry that decided the result all appear one clock after the inputs are presented. Programming the entries, raising traps and lock/write-protection of the configuration are handled elsewhere in the pipeline.

Top module: `mpc_top`

## Requirements
- R1: Outputs are registered. `allow_q`, `hit_q` and `hit_idx_q` reflect the inputs present at the previous rising clock edge. A synchronous active-high `rst` clears all three to zero.
- R2: Encodings are fixed as follows.
  - Configuration byte: R in bit 0, W in bit 1, X in bit 2, address mode in bits 4:3 (0 off, 1 top-of-range, 2 naturally aligned 4-byte, 3 naturally aligned power of two), lock in bit 7. Bits 6:5 have no effect.
  - Address registers hold the byte address shifted right by 2.
  - Privilege: 0 user, 1 supervisor, 3 machine.
  - `acc_perm`: bit 0 read, bit 1 write, bit 2 execute.
  - `sec_ctl`: bit 0 lockdown, bit 1 whitelist.
- R3: An entry matches only if its mode is not off and both the first byte (`acc_addr`) and the last byte (`acc_addr + acc_size - 1`, with `acc_size` ≥ 1) lie inside its region. The regions are:
  - Top-of-range: the half-open span from the previous entry's register ×4 (zero for entry 0) up to its own register ×4.
  - 4-byte: the four bytes at register ×4.
  - Power of two: with t trailing ones in the register, a 2^(t+3)-byte span.
- R4: When several entries match, the lowest-indexed one alone decides the result. `hit_q` is 1 and `hit_idx_q` carries that index.
- R5: With lockdown clear, a matching entry grants R, W and X to machine mode when the entry is unlocked. In every other case it grants exactly its own R/W/X bits.
- R6: With lockdown set, machine mode's grant for code {L,R,W,X} (L in bit 3, X in bit 0) is:
  - nothing for 0, 1 and 4 through 8;
  - RW for 2, 3 and 14;
  - X for 9 and 10;
  - RX for 11 and 13;
  - R for 12 and 15.
- R7: With lockdown set, the grant for the lower modes is:
  - nothing for 0, 8, 9, 12, 13 and 14;
  - X for 1, 10 and 11;
  - R for 2, 4 and 15;
  - RW for 3 and 6;
  - RX for 5;
  - RWX for 7.
- R8: A matched access is allowed only if every requested permission bit is inside the grant.
- R9: With no entry enabled, the access is denied in two cases: when whitelist is set, or when lockdown is set and the access is either not from machine mode or requests execute. Otherwise it is allowed, and `hit_q` is 0.
- R10: With at least one entry enabled and none matching, lower-mode accesses are denied. A machine-mode access is allowed only if whitelist is clear, and it is still denied if lockdown is set and execute is requested.
- R11: `sec_ctl` bit 2 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_size | input | SIZE_W | Access length in bytes (≥ 1) |
| acc_perm | input | 3 | Requested permissions {X,W,R} |
| acc_priv | input | 2 | Privilege of the access |
| ent_cfg | input | N_ENTRIES*8 | Configuration bytes, entry i at bits 8i+7:8i |
| ent_addr | input | N_ENTRIES*(ADDR_W-2) | Address registers, entry i at slice i |
| sec_ctl | input | 3 | Security control bits |
| allow_q | output | 1 | Access permitted |
| hit_q | output | 1 | An entry matched |
| hit_idx_q | output | IDX_W | Index of the deciding entry |

## Verification
The bench probes three kinds of corner case.

**Region boundaries.** Accesses straddle a region's lower edge or its exclusive top, and these must report no match. A checker that tested only the first byte would wrongly allow them.

**Priority.** An access falls in two overlapping entries and the lower one forbids it. A design that fell through to the next match would grant the write.

**Lockdown table and fallbacks.** All sixteen lockdown codes are swept for both machine and user mode against single and combined requests, so one mis-set table cell shows up as a wrong allow. The fallback rules are exercised with zero entries enabled and with a miss while entries are enabled. The bench also confirms that the spare control bit changes nothing.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

  localparam int CFG_W = 8;
  localparam int BIT_R = 0;
  localparam int BIT_W = 1;
  localparam int BIT_X = 2;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amatch_e;

  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    amatch_e    amode;
    logic       x;
    logic       w;
    logic       r;
  } entry_cfg_t;

  // Permission vector ordered {X,W,R}
  typedef logic [2:0] perm_t;

  localparam perm_t P_NONE = 3'b000;
  localparam perm_t P_R    = 3'b001;
  localparam perm_t P_RW   = 3'b011;
  localparam perm_t P_X    = 3'b100;
  localparam perm_t P_RX   = 3'b101;
  localparam perm_t P_RWX  = 3'b111;

  // Lockdown grant, code = {L,R,W,X}
  function automatic perm_t lockdown_grant(input logic [3:0] code, input logic m_mode);
    perm_t g;
    g = P_NONE;
    if (m_mode) begin
      case (code)
        4'd2, 4'd3, 4'd14:  g = P_RW;
        4'd9, 4'd10:        g = P_X;
        4'd11, 4'd13:       g = P_RX;
        4'd12, 4'd15:       g = P_R;
        default:            g = P_NONE;
      endcase
    end else begin
      case (code)
        4'd1, 4'd10, 4'd11: g = P_X;
        4'd2, 4'd4, 4'd15:  g = P_R;
        4'd3, 4'd6:         g = P_RW;
        4'd5:               g = P_RX;
        4'd7:               g = P_RWX;
        default:            g = P_NONE;
      endcase
    end
    return g;
  endfunction

endpackage

// File: rtl/mpc_region_match.sv
module mpc_region_match
  import mpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int PA_W = ADDR_W - 2
) (
  input  amatch_e           amode,
  input  logic [PA_W-1:0]   pa_cur,
  input  logic [PA_W-1:0]   pa_prev,
  input  logic [ADDR_W-1:0] first_b,
  input  logic [ADDR_W-1:0] last_b,
  output logic              hit
);

  logic [PA_W-1:0]   word_mask;
  logic [ADDR_W-1:0] lo_b, hi_b, mask_b, base_b;
  logic              tor_first, tor_last, pow_first, pow_last;

  // trailing ones plus the next bit form the span mask in power-of-two mode
  assign word_mask = (amode == AM_NAPOT)
                   ? (pa_cur ^ (pa_cur + {{(PA_W-1){1'b0}}, 1'b1})) : '0;
  assign mask_b    = {word_mask, 2'b11};
  assign base_b    = {pa_cur, 2'b00} | mask_b;
  assign lo_b      = {pa_prev, 2'b00};
  assign hi_b      = {pa_cur, 2'b00};

  assign tor_first = (first_b >= lo_b) && (first_b < hi_b);
  assign tor_last  = (last_b  >= lo_b) && (last_b  < hi_b);
  assign pow_first = ((first_b | mask_b) == base_b);
  assign pow_last  = ((last_b  | mask_b) == base_b);

  always_comb begin
    unique case (amode)
      AM_OFF:  hit = 1'b0;
      AM_TOR:  hit = tor_first && tor_last;
      default: hit = pow_first && pow_last;
    endcase
  end

endmodule

// File: rtl/mpc_first_hit.sv
module mpc_first_hit #(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [N_ENTRIES-1:0] hits,
  output logic                 any,
  output logic [IDX_W-1:0]     idx
);

  // scan downward so the lowest set index is the last one written
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/mpc_grant_decode.sv
module mpc_grant_decode
  import mpc_pkg::*;
(
  input  entry_cfg_t cfg,
  input  logic       m_mode,
  input  logic       lockdown,
  output perm_t      grant
);

  perm_t own_bits;
  assign own_bits = {cfg.x, cfg.w, cfg.r};

  always_comb begin
    if (lockdown)
      grant = lockdown_grant({cfg.lock, cfg.r, cfg.w, cfg.x}, m_mode);
    else if (m_mode && !cfg.lock)
      grant = P_RWX;
    else
      grant = own_bits;
  end

endmodule

// File: rtl/mpc_top.sv
module mpc_top
  import mpc_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 4,
  localparam int PA_W  = ADDR_W - 2,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic [SIZE_W-1:0]         acc_size,
  input  logic [2:0]                acc_perm,
  input  logic [1:0]                acc_priv,
  input  logic [N_ENTRIES*8-1:0]    ent_cfg,
  input  logic [N_ENTRIES*PA_W-1:0] ent_addr,
  input  logic [2:0]                sec_ctl,
  output logic                      allow_q,
  output logic                      hit_q,
  output logic [IDX_W-1:0]          hit_idx_q
);

  entry_cfg_t             cfg_arr [N_ENTRIES];
  logic [N_ENTRIES-1:0]   enabled;
  logic [N_ENTRIES-1:0]   hits;
  logic [N_ENTRIES*2-1:0] rsvd_bits;
  logic [ADDR_W-1:0]      last_b;
  logic                   any_hit, any_en, is_m, lockdown, whitelist, perm_ok, allow_d;
  logic [IDX_W-1:0]       sel_idx;
  perm_t                  grant;
  logic                   unused_bits;

  assign last_b    = acc_addr + ADDR_W'(acc_size) - {{(ADDR_W-1){1'b0}}, 1'b1};
  assign is_m      = (acc_priv == 2'(PRIV_M));
  assign lockdown  = sec_ctl[0];
  assign whitelist = sec_ctl[1];

  for (genvar gi = 0; gi < N_ENTRIES; gi++) begin : g_ent
    logic [PA_W-1:0] prev_pa;
    if (gi == 0) begin : g_base
      assign prev_pa = '0;
    end else begin : g_chain
      assign prev_pa = ent_addr[(gi-1)*PA_W +: PA_W];
    end
    assign cfg_arr[gi]            = entry_cfg_t'(ent_cfg[gi*CFG_W +: CFG_W]);
    assign enabled[gi]            = (cfg_arr[gi].amode != AM_OFF);
    assign rsvd_bits[gi*2 +: 2]   = cfg_arr[gi].rsvd;

    mpc_region_match #(.ADDR_W(ADDR_W)) u_match (
      .amode   (cfg_arr[gi].amode),
      .pa_cur  (ent_addr[gi*PA_W +: PA_W]),
      .pa_prev (prev_pa),
      .first_b (acc_addr),
      .last_b  (last_b),
      .hit     (hits[gi])
    );
  end

  assign any_en      = |enabled;
  assign unused_bits = sec_ctl[2] ^ (^rsvd_bits);

  mpc_first_hit #(.N_ENTRIES(N_ENTRIES)) u_pick (
    .hits (hits),
    .any  (any_hit),
    .idx  (sel_idx)
  );

  mpc_grant_decode u_grant (
    .cfg      (cfg_arr[sel_idx]),
    .m_mode   (is_m),
    .lockdown (lockdown),
    .grant    (grant)
  );

  assign perm_ok = ((acc_perm & ~grant) == 3'b000);

  always_comb begin
    if (!any_en)
      allow_d = !whitelist && !(lockdown && (!is_m || acc_perm[BIT_X]));
    else if (any_hit)
      allow_d = perm_ok;
    else
      allow_d = is_m && !whitelist && !(lockdown && acc_perm[BIT_X]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      allow_q   <= 1'b0;
      hit_q     <= 1'b0;
      hit_idx_q <= '0;
    end else begin
      allow_q   <= allow_d;
      hit_q     <= any_hit;
      hit_idx_q <= any_hit ? sel_idx : '0;
    end
  end

endmodule

// File: rtl/mpc_top_props.sv
module mpc_top_props #(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic [2:0]             acc_perm,
  input logic [1:0]             acc_priv,
  input logic [N_ENTRIES*8-1:0] ent_cfg,
  input logic [2:0]             sec_ctl,
  input logic                   allow_q,
  input logic                   hit_q,
  input logic [IDX_W-1:0]       hit_idx_q
);

  function automatic logic [1:0] mode_of(input logic [N_ENTRIES*8-1:0] v, input int i);
    return v[i*8+3 +: 2];
  endfunction

  function automatic logic lock_of(input logic [N_ENTRIES*8-1:0] v, input int i);
    return v[i*8+7];
  endfunction

  function automatic logic some_enabled(input logic [N_ENTRIES*8-1:0] v);
    logic e;
    e = 1'b0;
    for (int i = 0; i < N_ENTRIES; i++) e = e | (v[i*8+3 +: 2] != 2'd0);
    return e;
  endfunction

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!allow_q && !hit_q && hit_idx_q == '0));

  assert_hit_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> (mode_of($past(ent_cfg), int'(hit_idx_q)) != 2'd0));

  assert_lock_mexec_R6: assert property (@(posedge clk) disable iff (rst)
    (allow_q && $past(sec_ctl[0]) && $past(acc_priv) == 2'd3 && $past(acc_perm[2]))
      |-> (hit_q && lock_of($past(ent_cfg), int'(hit_idx_q))));

  assert_lock_lower_R7: assert property (@(posedge clk) disable iff (rst)
    (allow_q && $past(sec_ctl[0]) && $past(acc_priv) != 2'd3) |-> hit_q);

  assert_whitelist_empty_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(sec_ctl[1]) && !some_enabled($past(ent_cfg))) |-> !allow_q);

  assert_lower_miss_R10: assert property (@(posedge clk) disable iff (rst)
    (!hit_q && $past(acc_priv) != 2'd3 && some_enabled($past(ent_cfg))) |-> !allow_q);

endmodule

bind mpc_top mpc_top_props #(.N_ENTRIES(N_ENTRIES)) props_i (
  .clk       (clk),
  .rst       (rst),
  .acc_perm  (acc_perm),
  .acc_priv  (acc_priv),
  .ent_cfg   (ent_cfg),
  .sec_ctl   (sec_ctl),
  .allow_q   (allow_q),
  .hit_q     (hit_q),
  .hit_idx_q (hit_idx_q)
);

// File: tb/mpc_top_tb_top.sv
`timescale 1ns/1ps
module mpc_top_tb_top;

  localparam int N  = 8;
  localparam int AW = 32;
  localparam int SW = 4;
  localparam int PW = AW - 2;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] acc_addr = '0;
  logic [SW-1:0] acc_size = 4'd4;
  logic [2:0]    acc_perm = 3'd1;
  logic [1:0]    acc_priv = 2'd0;
  logic [N*8-1:0]  ent_cfg  = '0;
  logic [N*PW-1:0] ent_addr = '0;
  logic [2:0]    sec_ctl = 3'd0;
  logic          allow_q, hit_q;
  logic [IW-1:0] hit_idx_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mpc_top #(.N_ENTRIES(N), .ADDR_W(AW), .SIZE_W(SW)) dut_i (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_perm(acc_perm), .acc_priv(acc_priv), .ent_cfg(ent_cfg),
    .ent_addr(ent_addr), .sec_ctl(sec_ctl), .allow_q(allow_q),
    .hit_q(hit_q), .hit_idx_q(hit_idx_q)
  );

  typedef struct packed {
    logic [2:0]  sec;
    logic [1:0]  priv;
    logic [2:0]  req;
    logic [31:0] addr;
    logic [3:0]  size;
    logic        allow;
    logic        hit;
    logic [2:0]  idx;
    logic [3:0]  rtag;
  } vec_t;

  // entries: 0 NA4 @0x1000 R; 1 TOR [0x1000,0x2000) RW;
  // 2 pow2 0x4000..0x4FFF RWX; 3 pow2 0x5000..0x5FFF locked R
  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 3'd1, 32'h1000, 4'd4, 1'b1, 1'b1, 3'd0, 4'd4},  // R4 lowest wins
    '{3'd0, 2'd0, 3'd2, 32'h1000, 4'd4, 1'b0, 1'b1, 3'd0, 4'd4},  // R4 no fall-through
    '{3'd0, 2'd0, 3'd2, 32'h1004, 4'd4, 1'b1, 1'b1, 3'd1, 4'd3},  // R3 TOR
    '{3'd0, 2'd0, 3'd1, 32'h0FFE, 4'd4, 1'b0, 1'b0, 3'd0, 4'd3},  // R3 straddles low edge
    '{3'd0, 2'd3, 3'd2, 32'h1000, 4'd4, 1'b1, 1'b1, 3'd0, 4'd5},  // R5 M unlocked
    '{3'd0, 2'd3, 3'd2, 32'h5000, 4'd4, 1'b0, 1'b1, 3'd3, 4'd5},  // R5 M locked
    '{3'd0, 2'd3, 3'd1, 32'h9000, 4'd4, 1'b1, 1'b0, 3'd0, 4'd10}, // R10
    '{3'd2, 2'd3, 3'd1, 32'h9000, 4'd4, 1'b0, 1'b0, 3'd0, 4'd10}, // R10 whitelist
    '{3'd0, 2'd0, 3'd4, 32'h4FFC, 4'd4, 1'b1, 1'b1, 3'd2, 4'd3},  // R3 pow2 top
    '{3'd0, 2'd0, 3'd1, 32'h1FFE, 4'd4, 1'b0, 1'b0, 3'd0, 4'd3},  // R3 straddles top
    '{3'd1, 2'd3, 3'd4, 32'h9000, 4'd4, 1'b0, 1'b0, 3'd0, 4'd10}, // R10 lockdown exec
    '{3'd1, 2'd3, 3'd1, 32'h9000, 4'd4, 1'b1, 1'b0, 3'd0, 4'd10}, // R10 lockdown read
    '{3'd1, 2'd0, 3'd1, 32'h5000, 4'd4, 1'b0, 1'b1, 3'd3, 4'd7},  // R7 code 12
    '{3'd1, 2'd3, 3'd1, 32'h5000, 4'd4, 1'b1, 1'b1, 3'd3, 4'd6},  // R6 code 12
    '{3'd1, 2'd3, 3'd1, 32'h1000, 4'd4, 1'b0, 1'b1, 3'd0, 4'd6},  // R6 code 4
    '{3'd4, 2'd0, 3'd1, 32'h1000, 4'd4, 1'b1, 1'b1, 3'd0, 4'd11}, // R11
    '{3'd5, 2'd3, 3'd1, 32'h5000, 4'd4, 1'b1, 1'b1, 3'd3, 4'd11}, // R11
    '{3'd0, 2'd1, 3'd1, 32'h4000, 4'd8, 1'b1, 1'b1, 3'd2, 4'd3},  // R3 S mode
    '{3'd0, 2'd1, 3'd3, 32'h4FF8, 4'd8, 1'b1, 1'b1, 3'd2, 4'd8},  // R8 subset
    '{3'd0, 2'd0, 3'd5, 32'h1004, 4'd4, 1'b0, 1'b1, 3'd1, 4'd8},  // R8 missing X
    '{3'd1, 2'd0, 3'd1, 32'h9000, 4'd4, 1'b0, 1'b0, 3'd0, 4'd10}, // R10 lower miss
    '{3'd0, 2'd3, 3'd4, 32'h5FFC, 4'd4, 1'b0, 1'b1, 3'd3, 4'd5},  // R5 locked exec
    '{3'd0, 2'd0, 3'd1, 32'h1FFC, 4'd4, 1'b1, 1'b1, 3'd1, 4'd3},  // R3 last word of TOR
    '{3'd0, 2'd0, 3'd1, 32'h2000, 4'd1, 1'b0, 1'b0, 3'd0, 4'd3}   // R3 TOR top exclusive
  };

  function automatic logic [2:0] exp_grant(input logic [3:0] k, input logic m);
    logic [2:0] g;
    g = 3'b000;
    if (m) begin
      if (k == 2 || k == 3 || k == 14) g = 3'b011;
      if (k == 9 || k == 10)           g = 3'b100;
      if (k == 11 || k == 13)          g = 3'b101;
      if (k == 12 || k == 15)          g = 3'b001;
    end else begin
      if (k == 1 || k == 10 || k == 11) g = 3'b100;
      if (k == 2 || k == 4 || k == 15)  g = 3'b001;
      if (k == 3 || k == 6)             g = 3'b011;
      if (k == 5)                       g = 3'b101;
      if (k == 7)                       g = 3'b111;
    end
    return g;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic set_entry(input int i, input logic [7:0] c, input logic [PW-1:0] pa);
    ent_cfg[i*8 +: 8]   = c;
    ent_addr[i*PW +: PW] = pa;
  endtask

  task automatic clear_entries();
    ent_cfg  = '0;
    ent_addr = '0;
  endtask

  task automatic run(input string tag, input logic [2:0] sec, input logic [1:0] priv,
                     input logic [2:0] req, input logic [31:0] addr, input logic [3:0] size,
                     input logic ea, input logic eh, input logic [2:0] ei);
    @(negedge clk);
    sec_ctl = sec; acc_priv = priv; acc_perm = req; acc_addr = addr; acc_size = size;
    @(negedge clk);
    check(tag, "allow", {31'd0, allow_q}, {31'd0, ea});
    check(tag, "hit", {31'd0, hit_q}, {31'd0, eh});
    if (eh) check(tag, "idx", {29'd0, hit_idx_q}, {29'd0, ei});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs at zero even for an allowable access
    repeat (3) @(negedge clk);
    check("R1", "allow in reset", {31'd0, allow_q}, 32'd0);
    check("R1", "hit in reset", {31'd0, hit_q}, 32'd0);
    check("R1", "idx in reset", {29'd0, hit_idx_q}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "allow one cycle after reset", {31'd0, allow_q}, 32'd1);

    // R9: no entry enabled
    run("R9", 3'd0, 2'd0, 3'd1, 32'h100, 4'd4, 1'b1, 1'b0, 3'd0);
    run("R9", 3'd2, 2'd3, 3'd1, 32'h100, 4'd4, 1'b0, 1'b0, 3'd0);
    run("R9", 3'd1, 2'd0, 3'd1, 32'h100, 4'd4, 1'b0, 1'b0, 3'd0);
    run("R9", 3'd1, 2'd3, 3'd1, 32'h100, 4'd4, 1'b1, 1'b0, 3'd0);
    run("R9", 3'd1, 2'd3, 3'd4, 32'h100, 4'd4, 1'b0, 1'b0, 3'd0);
    run("R11", 3'd4, 2'd0, 3'd1, 32'h100, 4'd4, 1'b1, 1'b0, 3'd0);

    // table walk (R2 encodings throughout)
    set_entry(0, 8'h11, 30'h400);
    set_entry(1, 8'h0B, 30'h800);
    set_entry(2, 8'h1F, 30'h11FF);
    set_entry(3, 8'h99, 30'h15FF);
    for (int v = 0; v < NV; v++) begin
      run($sformatf("R%0d", VECS[v].rtag), VECS[v].sec, VECS[v].priv, VECS[v].req,
          VECS[v].addr, VECS[v].size, VECS[v].allow, VECS[v].hit, VECS[v].idx);
    end

    // R6 / R7 / R8: full lockdown code sweep on one 4-byte entry
    clear_entries();
    for (int k = 0; k < 16; k++) begin
      logic [3:0] kk;
      kk = 4'(k);
      set_entry(0, {kk[3], 2'b00, 2'b10, kk[0], kk[1], kk[2]}, 30'h400);
      for (int mi = 0; mi < 2; mi++) begin
        for (int ri = 0; ri < 4; ri++) begin
          logic [2:0] rq;
          logic [2:0] g;
          rq = (ri == 0) ? 3'd1 : (ri == 1) ? 3'd2 : (ri == 2) ? 3'd4 : 3'd3;
          g  = exp_grant(kk, mi == 1);
          run((mi == 1) ? "R6" : "R7", 3'd1, (mi == 1) ? 2'd3 : 2'd0, rq, 32'h1000, 4'd4,
              ((rq & ~g) == 3'd0), 1'b1, 3'd0);
        end
      end
    end

    // R1: reset reasserted mid-run clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "allow after re-reset", {31'd0, allow_q}, 32'd0);
    check("R1", "hit after re-reset", {31'd0, hit_q}, 32'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule